// File: doc/BRIEF.md
# Double-Buffered Configuration Store

This block holds two banks of configuration words for a region of reconfigurable logic. One bank is active and drives the configuration outputs in every cycle. The other bank is the shadow. A loader fills the shadow through a word-addressed write port while the active bank keeps running. A single swap command exchanges the two roles at one clock edge. The controlled logic therefore changes function with no dead cycles, and the bank it leaves behind becomes free to reload.

The block also holds a small set of user state registers for the controlled logic, which writes them through its own port. At each accepted swap, the incoming configuration decides, register by register, whether each one restarts from an initial value or keeps its contents. A shadow-ready flag protects against switching to a bank that is only partly loaded. A swap issued before the shadow is complete is refused and reported.

Top module: `cfg_plane_store`

## Requirements
- R1: After reset, bank 0 is active (`active_plane_o`=0), every configuration output word is zero, every user register is zero, and `shadow_ready_o` and `swap_err_o` are low.
- R2: A write with `wr_en_i` high stores `wr_data_i` at `wr_addr_i` in the shadow bank and never in the active bank. The stored word appears on `cfg_o` only after a later accepted swap.
- R3: A swap is accepted when `swap_i` is high and `shadow_ready_o` is high. On the clock edge that ends that cycle, `active_plane_o` toggles and `cfg_o` presents the former shadow contents, with word w on bits [32w+31:32w].
- R4: `cfg_o` holds its value across every edge that does not complete an accepted swap.
- R5: `shadow_ready_o` sets after a write to the last address (15). It clears on an accepted swap. A write to address 15 in the same cycle as an accepted swap leaves it clear.
- R6: A swap while `shadow_ready_o` is low changes nothing: the active bank and the user registers stay as they are. `swap_err_o` is then high for exactly the following cycle, and it is low at all other times.
- R7: A write in the same cycle as an accepted swap lands in the bank that was shadow before the swap. It is therefore visible on `cfg_o` straight after the swap.
- R8: On an accepted swap, user register k keeps its value if bit k of word 15 of the incoming bank is 1. If that bit is 0, the register loads word k of the incoming bank, taken before any write in that same cycle.
- R9: `ureg_we_i` writes `ureg_wdata_i` into user register `ureg_idx_i`, and `ureg_o` carries register k on bits [32k+31:32k]. A register that is being initialised by an accepted swap ignores a write in the same cycle. A preserved register takes the write.
- R10: After a swap, the bank that was active becomes the shadow. It can be rewritten, and a second swap brings it back with the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Shadow write strobe |
| wr_addr_i | input | 4 | Shadow word address |
| wr_data_i | input | 32 | Shadow write data |
| swap_i | input | 1 | Swap request |
| ureg_we_i | input | 1 | User register write strobe |
| ureg_idx_i | input | 2 | User register index |
| ureg_wdata_i | input | 32 | User register write data |
| cfg_o | output | 512 | Active bank, 16 words flattened |
| active_plane_o | output | 1 | Index of the active bank |
| shadow_ready_o | output | 1 | Shadow fully loaded |
| swap_err_o | output | 1 | Previous-cycle swap was refused |
| ureg_o | output | 128 | User registers, 4 words flattened |

## Verification
The properties assume a loader that writes the whole shadow with address 15 last, and they treat a swap as legal only when `shadow_ready_o` is high. The stimulus follows this rule. Each round fills all 16 shadow words in ascending order and only then swaps, sweeping all 16 preserve masks. The refused swaps and the collisions of a swap with a write or a register update are placed as separate directed cycles, so every illegal case is deliberate.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {
    SWAP_NONE   = 2'd0,
    SWAP_TAKE   = 2'd1,
    SWAP_REJECT = 2'd2
  } swap_evt_e;
endpackage

// File: rtl/cps_swap_ctrl.sv
module cps_swap_ctrl #(
  parameter int WORDS = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                swap_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  output logic                sel_o,
  output logic                ready_o,
  output logic                err_o,
  output cps_pkg::swap_evt_e  evt_o
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic sel_q, ready_q, err_q;

  always_comb begin
    if (!swap_i)       evt_o = cps_pkg::SWAP_NONE;
    else if (ready_q)  evt_o = cps_pkg::SWAP_TAKE;
    else               evt_o = cps_pkg::SWAP_REJECT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (evt_o == cps_pkg::SWAP_REJECT);
      if (evt_o == cps_pkg::SWAP_TAKE) begin
        sel_q   <= ~sel_q;
        ready_q <= 1'b0;  // a simultaneous write hits the new active bank
      end else if (wr_en_i && wr_addr_i == LAST) begin
        ready_q <= 1'b1;
      end
    end
  end

  assign sel_o   = sel_q;
  assign ready_o = ready_q;
  assign err_o   = err_q;
endmodule

// File: rtl/cps_plane_bank.sv
module cps_plane_bank #(
  parameter int WORDS = 16,
  parameter int WIDTH = 32,
  parameter int NUREG = 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sel_i,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [WIDTH-1:0]       wr_data_i,
  output logic [WORDS*WIDTH-1:0] cfg_o,
  output logic [NUREG*WIDTH-1:0] shd_init_o,
  output logic [NUREG-1:0]       shd_keep_o
);
  logic [WIDTH-1:0] plane_q [2][WORDS];
  logic             shd;

  assign shd = ~sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < WORDS; w++)
          plane_q[p][w] <= '0;
    end else if (wr_en_i) begin
      plane_q[shd][wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_out
    assign cfg_o[w*WIDTH +: WIDTH] = plane_q[sel_i][w];
  end

  for (genvar k = 0; k < NUREG; k++) begin : g_init
    assign shd_init_o[k*WIDTH +: WIDTH] = plane_q[shd][k];
  end

  assign shd_keep_o = plane_q[shd][WORDS-1][NUREG-1:0];
endmodule

// File: rtl/cps_ureg_bank.sv
module cps_ureg_bank #(
  parameter int WIDTH = 32,
  parameter int NUREG = 4,
  localparam int UIW = (NUREG > 1) ? $clog2(NUREG) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  cps_pkg::swap_evt_e     evt_i,
  input  logic [NUREG*WIDTH-1:0] init_i,
  input  logic [NUREG-1:0]       keep_i,
  input  logic                   we_i,
  input  logic [UIW-1:0]         idx_i,
  input  logic [WIDTH-1:0]       wdata_i,
  output logic [NUREG*WIDTH-1:0] ureg_o
);
  for (genvar k = 0; k < NUREG; k++) begin : g_reg
    logic [WIDTH-1:0] q;
    logic             reload;

    assign reload = (evt_i == cps_pkg::SWAP_TAKE) && !keep_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (reload)                        q <= init_i[k*WIDTH +: WIDTH];
      else if (we_i && idx_i == UIW'(k))      q <= wdata_i;
    end

    assign ureg_o[k*WIDTH +: WIDTH] = q;
  end
endmodule

// File: rtl/cfg_plane_store.sv
module cfg_plane_store #(
  parameter int WORDS = 16,
  parameter int WIDTH = 32,
  parameter int NUREG = 4,
  localparam int AW  = $clog2(WORDS),
  localparam int UIW = (NUREG > 1) ? $clog2(NUREG) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [WIDTH-1:0]       wr_data_i,
  input  logic                   swap_i,
  input  logic                   ureg_we_i,
  input  logic [UIW-1:0]         ureg_idx_i,
  input  logic [WIDTH-1:0]       ureg_wdata_i,
  output logic [WORDS*WIDTH-1:0] cfg_o,
  output logic                   active_plane_o,
  output logic                   shadow_ready_o,
  output logic                   swap_err_o,
  output logic [NUREG*WIDTH-1:0] ureg_o
);
  cps_pkg::swap_evt_e     evt;
  logic                   sel;
  logic [NUREG*WIDTH-1:0] shd_init;
  logic [NUREG-1:0]       shd_keep;

  cps_swap_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swap_i    (swap_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .sel_o     (sel),
    .ready_o   (shadow_ready_o),
    .err_o     (swap_err_o),
    .evt_o     (evt)
  );

  cps_plane_bank #(.WORDS(WORDS), .WIDTH(WIDTH), .NUREG(NUREG)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .cfg_o      (cfg_o),
    .shd_init_o (shd_init),
    .shd_keep_o (shd_keep)
  );

  cps_ureg_bank #(.WIDTH(WIDTH), .NUREG(NUREG)) u_ureg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .init_i  (shd_init),
    .keep_i  (shd_keep),
    .we_i    (ureg_we_i),
    .idx_i   (ureg_idx_i),
    .wdata_i (ureg_wdata_i),
    .ureg_o  (ureg_o)
  );

  assign active_plane_o = sel;
endmodule

// File: rtl/cfg_plane_store_chk.sv
module cfg_plane_store_chk #(
  parameter int WORDS = 16,
  parameter int WIDTH = 32,
  parameter int NUREG = 4,
  localparam int AW  = $clog2(WORDS),
  localparam int UIW = (NUREG > 1) ? $clog2(NUREG) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [AW-1:0]          wr_addr_i,
  input logic                   swap_i,
  input logic                   ureg_we_i,
  input logic [WORDS*WIDTH-1:0] cfg_o,
  input logic                   active_plane_o,
  input logic                   shadow_ready_o,
  input logic                   swap_err_o,
  input logic [NUREG*WIDTH-1:0] ureg_o
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  // R3
  swap_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && shadow_ready_o) |=> (active_plane_o != $past(active_plane_o)));

  // R4
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(swap_i && shadow_ready_o) |=> $stable(cfg_o));

  // R5
  ready_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && shadow_ready_o) |=> !shadow_ready_o);

  // R5
  ready_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == LAST && !swap_i) |=> shadow_ready_o);

  // R6
  reject_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && !shadow_ready_o) |=> (swap_err_o && $stable(active_plane_o)));

  // R6
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(swap_i && !shadow_ready_o) |=> !swap_err_o);

  // R9
  ureg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(swap_i && shadow_ready_o) && !ureg_we_i) |=> $stable(ureg_o));
endmodule

bind cfg_plane_store cfg_plane_store_chk #(
  .WORDS(WORDS), .WIDTH(WIDTH), .NUREG(NUREG)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .swap_i         (swap_i),
  .ureg_we_i      (ureg_we_i),
  .cfg_o          (cfg_o),
  .active_plane_o (active_plane_o),
  .shadow_ready_o (shadow_ready_o),
  .swap_err_o     (swap_err_o),
  .ureg_o         (ureg_o)
);

// File: tb/cfg_plane_store_tb.sv
`timescale 1ns/1ps
module cfg_plane_store_tb;
  localparam int WORDS = 16;
  localparam int WIDTH = 32;
  localparam int NUREG = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [3:0]        wr_addr_i = '0;
  logic [31:0]       wr_data_i = '0;
  logic              swap_i = 1'b0;
  logic              ureg_we_i = 1'b0;
  logic [1:0]        ureg_idx_i = '0;
  logic [31:0]       ureg_wdata_i = '0;
  logic [511:0]      cfg_o;
  logic              active_plane_o, shadow_ready_o, swap_err_o;
  logic [127:0]      ureg_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] m_plane [2][WORDS];
  logic        m_sel, m_ready, m_err;
  logic [31:0] m_ureg [NUREG];

  always #2.5 clk_i = ~clk_i;

  cfg_plane_store #(.WORDS(WORDS), .WIDTH(WIDTH), .NUREG(NUREG)) u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .swap_i,
    .ureg_we_i, .ureg_idx_i, .ureg_wdata_i,
    .cfg_o, .active_plane_o, .shadow_ready_o, .swap_err_o, .ureg_o
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " active"}, 32'(active_plane_o), 32'(m_sel));
    chk({tag, " ready"},  32'(shadow_ready_o), 32'(m_ready));
    chk({tag, " err"},    32'(swap_err_o),     32'(m_err));
    for (int w = 0; w < WORDS; w++)
      chk({tag, " cfg"}, cfg_o[w*32 +: 32], m_plane[m_sel][w]);
    for (int k = 0; k < NUREG; k++)
      chk({tag, " ureg"}, ureg_o[k*32 +: 32], m_ureg[k]);
  endtask

  // one clock with the given inputs; expected state follows the requirements
  task automatic cycle(input logic we, input logic [3:0] a, input logic [31:0] d,
                       input logic sw, input logic uwe, input logic [1:0] ui,
                       input logic [31:0] ud);
    logic        take;
    int          sh;
    logic [31:0] nu [NUREG];
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; swap_i = sw;
    ureg_we_i = uwe; ureg_idx_i = ui; ureg_wdata_i = ud;
    take = sw && m_ready;
    sh   = m_sel ? 0 : 1;
    for (int k = 0; k < NUREG; k++) begin
      if (take && !m_plane[sh][WORDS-1][k]) nu[k] = m_plane[sh][k];
      else if (uwe && ui == 2'(k))          nu[k] = ud;
      else                                  nu[k] = m_ureg[k];
    end
    for (int k = 0; k < NUREG; k++) m_ureg[k] = nu[k];
    if (we) m_plane[sh][a] = d;
    m_err = sw && !m_ready;
    if (take) begin
      m_ready = 1'b0;
      m_sel   = ~m_sel;
    end else if (we && a == 4'(WORDS-1)) begin
      m_ready = 1'b1;
    end
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; swap_i = 1'b0; ureg_we_i = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int r, input int a);
    if (a == WORDS-1) return 32'hC300_0000 | (32'(r) << 8) | 32'(r & 15);
    return 32'hA500_0000 | (32'(r) << 16) | (32'(a) * 32'h111);
  endfunction

  task automatic fill(input int r, input bit each_chk);
    for (int a = 0; a < WORDS; a++) begin
      cycle(1'b1, 4'(a), pat(r, a), 1'b0, 1'b0, 2'd0, 32'h0);
      if (each_chk) check_state("R2 R4 R5 fill");
    end
  endtask

  initial begin
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < WORDS; w++) m_plane[p][w] = '0;
    for (int k = 0; k < NUREG; k++) m_ureg[k] = '0;
    m_sel = 1'b0; m_ready = 1'b0; m_err = 1'b0;

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_state("R1 reset");

    // refused swap on an empty shadow
    cycle(1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 2'd0, 32'h0);
    check_state("R6 reject");
    chk("R6 err pulse", 32'(swap_err_o), 32'h1);
    cycle(1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
    check_state("R6 err drop");

    for (int k = 0; k < NUREG; k++) begin
      cycle(1'b0, 4'd0, 32'h0, 1'b0, 1'b1, 2'(k), 32'h100 + 32'(k));
      check_state("R9 ureg write");
    end

    // sweep all preserve masks; each round rewrites the bank left behind
    for (int r = 0; r < 16; r++) begin
      fill(r, 1'b1);
      cycle(1'b0, 4'd0, 32'h0, 1'b0, 1'b1, 2'(r % NUREG), 32'h5500_0000 | 32'(r));
      check_state("R9 ureg pre");
      cycle(1'b0, 4'd0, 32'h0, 1'b1, 1'b0, 2'd0, 32'h0);
      check_state("R3 R8 R10 swap");
      chk("R3 word0", cfg_o[31:0], pat(r, 0));
    end

    // swap colliding with a shadow write and a user register write
    fill(16, 1'b0);
    cycle(1'b1, 4'd3, 32'hDEAD_BEEF, 1'b1, 1'b1, 2'd0, 32'h0000_0123);
    check_state("R7 R8 R9 collide");
    chk("R7 word3", cfg_o[3*32 +: 32], 32'hDEAD_BEEF);
    chk("R8 pre-write init", ureg_o[3*32 +: 32], pat(16, 3));
    chk("R9 init wins", ureg_o[31:0], pat(16, 0));

    // swap colliding with a write to the last word
    fill(17, 1'b0);
    cycle(1'b1, 4'd15, 32'h0000_0001, 1'b1, 1'b0, 2'd0, 32'h0);
    check_state("R5 last-word collide");
    chk("R5 ready low", 32'(shadow_ready_o), 32'h0);

    // refused swap after that: nothing moves
    cycle(1'b0, 4'd0, 32'h0, 1'b1, 1'b1, 2'd1, 32'h0000_0777);
    check_state("R6 late reject");
    cycle(1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0);
    check_state("R6 quiet");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule